// File: doc/BRIEF.md
# Slave Instruction Protocol Sequencer

This block follows the transfer protocol of one coprocessor-style slave instruction. It sits behind a bus-cycle interface that delivers one beat per `bus_valid` pulse: a 2-bit status code and a 16-bit data word. A beat with status 11 carries an ID byte. Every slave sees it, and only the slave whose parameter `SLAVE_ID` equals the byte becomes selected.

The selected slave then takes an operation word with status 01. That word reaches the bus with its two bytes exchanged, so the block restores their order. A small decode of the word fixes how many operands follow and the size of each. Later status-01 beats deliver the operands. Each operand is assembled from one, two or four beats, least significant word first, and is issued with a one-cycle valid pulse together with its size code and its index.

Any ID beat cancels the instruction in progress and discards partly assembled words. An instruction that was aborted can therefore be retried in full, starting again from its ID beat.

Top module: `slv_proto_seq`

## Requirements
- R1: An ID beat (status 11) whose bits 7:0 equal `SLAVE_ID` sets `sel` on the next cycle. An ID beat with any other value clears `sel` and returns the block to idle.
- R2: A status-01 beat while the block is not selected produces no output pulse and leaves `sel` low.
- R3: The first status-01 beat after a matching ID raises `opw_valid` for one cycle with `opw = {bus_data[7:0], bus_data[15:8]}`.
- R4: The restored operation word sets the operand count from bits 1:0 and the size code of operand i from bits 2i+3:2i+2. Size code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. These values hold until the next ID beat.
- R5: An 8-bit operand is bus bits 7:0, zero-extended. A 16-bit operand is the full bus word, zero-extended.
- R6: A 32-bit operand takes 2 status-01 beats and a 64-bit operand takes 4. Each beat fills the next higher 16-bit slice, starting at bits 15:0.
- R7: Each completed operand raises `opd_valid` for exactly one cycle, together with `opd_size` and its index `opd_idx` counted from 0. It never coincides with `opw_valid`.
- R8: An ID beat cancels any instruction in progress. Partly received operand words are discarded, and a retried instruction is assembled only from beats that follow the new ID.
- R9: After the last operand, or right after an operation word whose count is 0, further status-01 beats are ignored. Beats with status 00 or 10 never have any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | One bus beat is present this cycle |
| bus_status | input | 2 | Status code of the beat |
| bus_data | input | 16 | Data bus of the beat |
| sel | output | 1 | This slave is selected by the last ID beat |
| opw_valid | output | 1 | One-cycle pulse: corrected operation word available |
| opw | output | 16 | Operation word in restored byte order |
| opd_valid | output | 1 | One-cycle pulse: an operand is complete |
| opd_data | output | 64 | Assembled operand, zero-extended |
| opd_size | output | 2 | Size code of the completed operand |
| opd_idx | output | 2 | Position of the operand within the instruction |

## Verification
A wrong state or a stale word counter shows up at the ports on the cycle the affected operand completes. The symptoms are a pulse that is missing or comes too early, a value built from shifted 16-bit slices, or a wrong index. An abort that fails to clear state leaves a word from the cancelled attempt inside the first operand of the retry, and the scoreboard compares exactly that value. A decode that is not restored correctly changes both `opw` and the number of operand pulses, and this is visible within a few cycles of the operation word.

// File: rtl/slv_seq_pkg.sv
package slv_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAITW = 2'd1,
    SQ_OPND  = 2'd2,
    SQ_DONE  = 2'd3
  } sq_state_e;

  localparam logic [1:0] STAT_ID   = 2'b11;
  localparam logic [1:0] STAT_XFER = 2'b01;

  // number of 16-bit beats for a size code
  function automatic logic [2:0] beats_for(input logic [1:0] sz);
    case (sz)
      2'd2:    beats_for = 3'd2;
      2'd3:    beats_for = 3'd4;
      default: beats_for = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/slv_id_match.sv
module slv_id_match #(
  parameter int          ID_W     = 8,
  parameter logic [7:0]  SLAVE_ID = 8'h5A
) (
  input  logic [ID_W-1:0] id_byte,
  output logic            hit
);
  always_comb hit = (id_byte == SLAVE_ID[ID_W-1:0]);
endmodule

// File: rtl/slv_opword_dec.sv
module slv_opword_dec #(
  parameter int BUS_W = 16,
  parameter int CNT_W = 2,
  parameter int SZ_W  = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUS_W-1:0] bus_word,
  input  logic [IDX_W-1:0] cur_idx,
  output logic [BUS_W-1:0] opw,
  output logic             opw_valid,
  output logic [CNT_W-1:0] next_count,
  output logic [CNT_W-1:0] op_count,
  output logic [SZ_W-1:0]  cur_size
);
  localparam int HALF = BUS_W / 2;

  logic [BUS_W-1:0] swapped;

  always_comb begin
    swapped    = {bus_word[HALF-1:0], bus_word[BUS_W-1:HALF]};
    next_count = swapped[CNT_W-1:0];
    op_count   = opw[CNT_W-1:0];
    cur_size   = opw[CNT_W + SZ_W*cur_idx +: SZ_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opw       <= '0;
      opw_valid <= 1'b0;
    end else begin
      opw_valid <= load;
      if (load) opw <= swapped;
    end
  end

  AST_SWAP_ORDER: assert property (@(posedge clk) disable iff (rst)
    opw_valid |-> opw == {$past(bus_word[HALF-1:0]), $past(bus_word[BUS_W-1:HALF])}); // R3

endmodule

// File: rtl/slv_opnd_asm.sv
module slv_opnd_asm
  import slv_seq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int OPND_W = 64,
  parameter int SZ_W   = 2,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              word_en,
  input  logic [BUS_W-1:0]  word_in,
  input  logic [SZ_W-1:0]   size,
  input  logic [IDX_W-1:0]  idx,
  output logic              last,
  output logic              opd_valid,
  output logic [OPND_W-1:0] opd_data,
  output logic [SZ_W-1:0]   opd_size,
  output logic [IDX_W-1:0]  opd_idx
);
  localparam int SLICES = OPND_W / BUS_W;
  localparam int WC_W   = $clog2(SLICES);

  logic [WC_W-1:0]   wcnt;
  logic [OPND_W-1:0] acc;
  logic [OPND_W-1:0] merged;

  always_comb begin
    last   = ({1'b0, wcnt} + 1'b1) == (WC_W+1)'(beats_for(size));
    merged = acc;
    merged[wcnt*BUS_W +: BUS_W] = word_in;
    if (size == '0) merged = {{(OPND_W-8){1'b0}}, word_in[7:0]};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wcnt      <= '0;
      acc       <= '0;
      opd_valid <= 1'b0;
      if (rst) begin
        opd_data <= '0;
        opd_size <= '0;
        opd_idx  <= '0;
      end
    end else begin
      opd_valid <= 1'b0;
      if (word_en) begin
        if (last) begin
          opd_valid <= 1'b1;
          opd_data  <= merged;
          opd_size  <= size;
          opd_idx   <= idx;
          wcnt      <= '0;
          acc       <= '0;
        end else begin
          acc  <= merged;
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, wcnt} < (WC_W+1)'(beats_for(size))) || !word_en); // R6

endmodule

// File: rtl/slv_proto_seq.sv
module slv_proto_seq
  import slv_seq_pkg::*;
#(
  parameter logic [7:0] SLAVE_ID = 8'h5A,
  parameter int         BUS_W    = 16,
  parameter int         OPND_W   = 64,
  parameter int         CNT_W    = 2,
  parameter int         SZ_W     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [1:0]        bus_status,
  input  logic [BUS_W-1:0]  bus_data,
  output logic              sel,
  output logic              opw_valid,
  output logic [BUS_W-1:0]  opw,
  output logic              opd_valid,
  output logic [OPND_W-1:0] opd_data,
  output logic [SZ_W-1:0]   opd_size,
  output logic [CNT_W-1:0]  opd_idx
);
  localparam int IDX_W = CNT_W;

  sq_state_e        state;
  logic [IDX_W-1:0] op_idx;
  logic             id_beat, xfer_beat, id_hit;
  logic [CNT_W-1:0] next_count, op_count;
  logic [SZ_W-1:0]  cur_size;
  logic             asm_last, word_en, load_opw;

  always_comb begin
    id_beat   = bus_valid && (bus_status == STAT_ID);
    xfer_beat = bus_valid && (bus_status == STAT_XFER);
    load_opw  = xfer_beat && (state == SQ_WAITW);
    word_en   = xfer_beat && (state == SQ_OPND);
  end

  slv_id_match #(.ID_W(8), .SLAVE_ID(SLAVE_ID)) u_id (
    .id_byte (bus_data[7:0]),
    .hit     (id_hit)
  );

  slv_opword_dec #(.BUS_W(BUS_W), .CNT_W(CNT_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .load       (load_opw),
    .bus_word   (bus_data),
    .cur_idx    (op_idx),
    .opw        (opw),
    .opw_valid  (opw_valid),
    .next_count (next_count),
    .op_count   (op_count),
    .cur_size   (cur_size)
  );

  slv_opnd_asm #(.BUS_W(BUS_W), .OPND_W(OPND_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .clear     (id_beat),
    .word_en   (word_en),
    .word_in   (bus_data),
    .size      (cur_size),
    .idx       (op_idx),
    .last      (asm_last),
    .opd_valid (opd_valid),
    .opd_data  (opd_data),
    .opd_size  (opd_size),
    .opd_idx   (opd_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      sel    <= 1'b0;
      op_idx <= '0;
    end else if (id_beat) begin
      // any broadcast restarts the protocol
      op_idx <= '0;
      sel    <= id_hit;
      state  <= id_hit ? SQ_WAITW : SQ_IDLE;
    end else if (xfer_beat) begin
      case (state)
        SQ_WAITW: state <= (next_count == '0) ? SQ_DONE : SQ_OPND;
        SQ_OPND: if (asm_last) begin
          op_idx <= op_idx + 1'b1;
          if (({1'b0, op_idx} + 1'b1) == {1'b0, op_count}) state <= SQ_DONE;
        end
        default: state <= state;
      endcase
    end
  end

  AST_IDLE_UNSEL: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> !sel); // R1
  AST_PULSE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    (opw_valid || opd_valid) |-> sel); // R2
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({opw_valid, opd_valid})); // R7
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    opd_valid |-> (opd_idx < op_count)); // R7
  AST_ID_ABORTS: assert property (@(posedge clk) disable iff (rst)
    id_beat |=> (!opd_valid && !opw_valid)); // R8

endmodule

// File: tb/slv_proto_seq_test.sv
module slv_proto_seq_test;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [1:0]  bus_status = 2'b00;
  logic [15:0] bus_data = '0;
  logic        sel, opw_valid, opd_valid;
  logic [15:0] opw;
  logic [63:0] opd_data;
  logic [1:0]  opd_size, opd_idx;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          is_opd;
    logic [63:0] data;
    logic [1:0]  size;
    logic [1:0]  idx;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  slv_proto_seq #(.SLAVE_ID(MY_ID)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_status(bus_status),
    .bus_data(bus_data), .sel(sel), .opw_valid(opw_valid), .opw(opw),
    .opd_valid(opd_valid), .opd_data(opd_data), .opd_size(opd_size), .opd_idx(opd_idx)
  );

  task automatic beat(input logic [1:0] st, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_status = st; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_status = 2'b00; bus_data = '0;
  endtask

  task automatic exp_opw(input logic [15:0] w, input string r);
    sb.push_back('{1'b0, {48'h0, w}, 2'd0, 2'd0, r});
  endtask

  task automatic exp_opd(input logic [63:0] d, input logic [1:0] s,
                         input logic [1:0] i, input string r);
    sb.push_back('{1'b1, d, s, i, r});
  endtask

  task automatic chk_sel(input logic e, input string r);
    checks++;
    if (sel !== e) begin
      errors++;
      $display("FAIL %s sel actual %b expected %b", r, sel, e);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (opw_valid || opd_valid)) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2/R9 unexpected pulse actual opw_v=%b opd_v=%b expected none",
                 opw_valid, opd_valid);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (!e.is_opd) begin
          if (!opw_valid || opd_valid || opw !== e.data[15:0]) begin
            errors++;
            $display("FAIL %s opw actual v=%b %h expected %h", e.req, opw_valid, opw, e.data[15:0]);
          end
        end else begin
          if (!opd_valid || opw_valid || opd_data !== e.data ||
              opd_size !== e.size || opd_idx !== e.idx) begin
            errors++;
            $display("FAIL %s opd actual %h s%0d i%0d expected %h s%0d i%0d",
                     e.req, opd_data, opd_size, opd_idx, e.data, e.size, e.idx);
          end
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (sel !== 1'b0 || opw_valid !== 1'b0 || opd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual sel=%b opw_v=%b opd_v=%b expected 0", sel, opw_valid, opd_valid);
    end

    // R2: operand beat while idle is ignored
    beat(2'b01, 16'h1234);
    repeat (2) @(negedge clk);
    chk_sel(1'b0, "R2");

    // R1: foreign ID
    beat(2'b11, 16'h00A7);
    chk_sel(1'b0, "R1");

    // R1,R3,R4,R5,R6: byte, half, 32-bit operands; opword low byte 0x93
    beat(2'b11, {8'h00, MY_ID});
    chk_sel(1'b1, "R1");
    exp_opw(16'hA593, "R3");
    beat(2'b01, 16'h93A5);
    exp_opd(64'h3C, 2'd0, 2'd0, "R5");
    beat(2'b01, 16'hFF3C);
    exp_opd(64'hBEEF, 2'd1, 2'd1, "R5");
    beat(2'b01, 16'hBEEF);
    exp_opd(64'h22221111, 2'd2, 2'd2, "R6");
    beat(2'b01, 16'h1111);
    beat(2'b01, 16'h2222);
    // R9: done, extra beat ignored
    beat(2'b01, 16'h9999);
    repeat (2) @(negedge clk);

    // R6,R9: one 64-bit operand, status 10/00 beats in between ignored
    beat(2'b11, {8'h00, MY_ID});
    exp_opw(16'h000D, "R4");
    beat(2'b01, 16'h0D00);
    exp_opd(64'h0718E5F6C3D4A1B2, 2'd3, 2'd0, "R6");
    beat(2'b01, 16'hA1B2);
    beat(2'b10, 16'hFFFF);
    beat(2'b01, 16'hC3D4);
    beat(2'b00, 16'hEEEE);
    beat(2'b01, 16'hE5F6);
    beat(2'b01, 16'h0718);
    repeat (2) @(negedge clk);

    // R8: abort mid-operand and retry
    beat(2'b11, {8'h00, MY_ID});
    exp_opw(16'h002A, "R8");
    beat(2'b01, 16'h2A00);
    beat(2'b01, 16'hDEAD);
    beat(2'b11, {8'h00, MY_ID});
    chk_sel(1'b1, "R8");
    exp_opw(16'h002A, "R8");
    beat(2'b01, 16'h2A00);
    exp_opd(64'h22221111, 2'd2, 2'd0, "R8");
    beat(2'b01, 16'h1111);
    beat(2'b01, 16'h2222);
    exp_opd(64'h44443333, 2'd2, 2'd1, "R7");
    beat(2'b01, 16'h3333);
    beat(2'b01, 16'h4444);
    repeat (2) @(negedge clk);

    // R4,R9: count 0, later beats ignored
    beat(2'b11, {8'h00, MY_ID});
    exp_opw(16'h7740, "R4");
    beat(2'b01, 16'h4077);
    beat(2'b01, 16'h5555);
    repeat (2) @(negedge clk);

    // R1,R8: foreign ID during active instruction deselects
    beat(2'b11, {8'h00, MY_ID});
    exp_opw(16'h0001, "R3");
    beat(2'b01, 16'h0100);
    beat(2'b11, 16'h0011);
    chk_sel(1'b0, "R1");
    beat(2'b01, 16'h6666);
    repeat (3) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R7 missing pulses actual %0d pending expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule